// File: doc/BRIEF.md
# Audio Processor Interval Timers and Control Register

This block holds the audio processor's control byte and three interval timers behind a byte-wide register port. Software writes a period into a timer's target register, then sets that timer's enable bit in the control byte. While enabled, the timer counts prescaled ticks. Each time the tick count reaches the target, it bumps a small up-counter that software reads and clears with a single read.

The same control write can also produce strobes. One strobe clears the lower pair of host mailbox ports and another clears the upper pair. The control byte also selects whether the 64-byte boot ROM is overlaid on the top of memory. The two tick enables come from prescalers outside the block. The memory array and the ROM contents are handled elsewhere.

Top module: `sndTimerCtl`

## Requirements
- R1: After reset, the control byte reads 80h, `romOverlay` is 1, every output counter reads 0, both clear strobes are 0, and every target is 0.
- R2: Register addresses: the control byte is at F1h. The target of timer i is at FAh+i. The output counter of timer i is at FDh+i and reads as {4'b0, count}. A read at any other address returns 00h. `rdData` is combinational from `addr` while `rdEn` is high.
- R3: An enabled timer increments its output counter once per `target` ticks, and a target of 0 gives a period of 256 ticks.
- R4: Timers 0 and 1 advance on `tickSlow` and timer 2 advances on `tickFast`. Ticks that arrive while the timer's enable bit (control bit i) is 0 leave its output counter unchanged.
- R5: Writing the control byte with bit i at 1 while bit i was 0 clears timer i's tick count and output counter. Writing 1 to an already enabled timer leaves its count running undisturbed.
- R6: The output counter is 4 bits wide and wraps from 15 to 0.
- R7: A read of an output counter returns its value and clears it at that clock edge. If an increment falls in the same cycle, the counter becomes 1.
- R8: A control write with bit 4 set pulses `clrPortsLo` high for exactly the following cycle. A control write with bit 5 set pulses `clrPortsHi` the same way.
- R9: `romOverlay` follows control bit 7 from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 8 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data (combinational) |
| tickSlow | input | 1 | Tick enable for timers 0 and 1 |
| tickFast | input | 1 | Tick enable for timer 2 |
| clrPortsLo | output | 1 | Clear pulse for mailbox ports 0 and 1 |
| clrPortsHi | output | 1 | Clear pulse for mailbox ports 2 and 3 |
| romOverlay | output | 1 | Boot ROM mapped at FFC0h-FFFFh when 1 |

## Verification
A corrupted tick count shows up as a wrong output counter value on the first read after the next target match. It therefore surfaces within one timer period. A missed or spurious restart shows on the very next counter read as a value that ignores, or wrongly keeps, the ticks before the control write. A misrouted strobe or overlay bit is visible on the outputs in the cycle after the control write.

// File: rtl/sndTimerPkg.sv
package sndTimerPkg;
  localparam int NTMR = 3;
  localparam logic [7:0] ADDR_CTRL = 8'hF1;
  localparam logic [7:0] ADDR_TGT0 = 8'hFA;
  localparam logic [7:0] ADDR_CNT0 = 8'hFD;
  localparam logic [7:0] CTRL_RST  = 8'h80;
  localparam int BIT_CLR_LO = 4;
  localparam int BIT_CLR_HI = 5;
  localparam int BIT_ROM    = 7;

  typedef struct packed {
    logic [NTMR-1:0] start;
    logic [NTMR-1:0] run;
    logic [NTMR-1:0] tgtWe;
    logic [NTMR-1:0] cntRd;
    logic [7:0]      wrByte;
  } tmrCtl_t;
endpackage

// File: rtl/sndTimerCtrl.sv
module sndTimerCtrl
  import sndTimerPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [7:0] addr,
  input  logic [7:0] wrData,
  output tmrCtl_t    ctl,
  output logic [7:0] ctrlByte,
  output logic       clrPortsLo,
  output logic       clrPortsHi,
  output logic       romOverlay
);
  logic [7:0] ctrlQ;
  logic       wrCtl;
  logic       clrLoQ, clrHiQ;

  assign wrCtl = wrEn && (addr == ADDR_CTRL);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ  <= CTRL_RST;
      clrLoQ <= 1'b0;
      clrHiQ <= 1'b0;
    end else begin
      clrLoQ <= wrCtl && wrData[BIT_CLR_LO];
      clrHiQ <= wrCtl && wrData[BIT_CLR_HI];
      if (wrCtl) ctrlQ <= wrData;
    end
  end

  for (genvar i = 0; i < NTMR; i++) begin : g_dec
    assign ctl.start[i] = wrCtl && wrData[i] && !ctrlQ[i];
    assign ctl.run[i]   = ctrlQ[i];
    assign ctl.tgtWe[i] = wrEn && (addr == 8'(ADDR_TGT0 + i));
    assign ctl.cntRd[i] = rdEn && (addr == 8'(ADDR_CNT0 + i));
  end
  assign ctl.wrByte = wrData;

  assign ctrlByte   = ctrlQ;
  assign clrPortsLo = clrLoQ;
  assign clrPortsHi = clrHiQ;
  assign romOverlay = ctrlQ[BIT_ROM];

  AST_CLR_LO_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    clrPortsLo |-> $past(wrCtl && wrData[BIT_CLR_LO])); // R8
  AST_CLR_HI_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    clrPortsHi |-> $past(wrCtl && wrData[BIT_CLR_HI])); // R8
  AST_ROM_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    wrCtl |=> (romOverlay == $past(wrData[BIT_ROM]))); // R9
endmodule

// File: rtl/sndTimerDp.sv
module sndTimerDp
  import sndTimerPkg::*;
#(
  parameter int          CNT_W     = 4,
  parameter logic [NTMR-1:0] FAST_MASK = 3'b100
) (
  input  logic       clk,
  input  logic       rstN,
  input  tmrCtl_t    ctl,
  input  logic       tickSlow,
  input  logic       tickFast,
  input  logic       rdEn,
  input  logic [7:0] addr,
  input  logic [7:0] ctrlByte,
  output logic [7:0] rdData
);
  logic [7:0]       tgtQ   [NTMR];
  logic [7:0]       innerQ [NTMR];
  logic [CNT_W-1:0] outQ   [NTMR];
  logic [NTMR-1:0]  hit;
  logic [NTMR-1:0]  tick;

  for (genvar i = 0; i < NTMR; i++) begin : g_tmr
    logic [8:0] nextInner;
    logic [8:0] effTgt;

    if (FAST_MASK[i]) begin : g_fast
      assign tick[i] = tickFast;
    end else begin : g_slow
      assign tick[i] = tickSlow;
    end

    assign nextInner = {1'b0, innerQ[i]} + 9'd1;
    assign effTgt    = {tgtQ[i] == 8'd0, tgtQ[i]};
    assign hit[i]    = ctl.run[i] && tick[i] && (nextInner == effTgt);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        tgtQ[i]   <= 8'd0;
        innerQ[i] <= 8'd0;
        outQ[i]   <= '0;
      end else begin
        if (ctl.tgtWe[i]) tgtQ[i] <= ctl.wrByte;
        if (ctl.start[i]) begin
          innerQ[i] <= 8'd0;
          outQ[i]   <= '0;
        end else begin
          if (ctl.run[i] && tick[i])
            innerQ[i] <= hit[i] ? 8'd0 : nextInner[7:0];
          if (ctl.cntRd[i])
            outQ[i] <= hit[i] ? CNT_W'(1) : '0;
          else if (hit[i])
            outQ[i] <= outQ[i] + CNT_W'(1);
        end
      end
    end

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
      ctl.start[i] |=> (outQ[i] == '0)); // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      (!ctl.run[i] && !ctl.start[i] && !ctl.cntRd[i]) |=> $stable(outQ[i])); // R4
    AST_RD_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
      (ctl.cntRd[i] && !hit[i] && !ctl.start[i]) |=> (outQ[i] == '0)); // R7
  end

  always_comb begin
    rdData = 8'h00;
    if (rdEn) begin
      if (addr == ADDR_CTRL) rdData = ctrlByte;
      for (int k = 0; k < NTMR; k++)
        if (addr == 8'(ADDR_CNT0 + k)) rdData = 8'(outQ[k]);
    end
  end
endmodule

// File: rtl/sndTimerCtl.sv
module sndTimerCtl
  import sndTimerPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [7:0] addr,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       tickSlow,
  input  logic       tickFast,
  output logic       clrPortsLo,
  output logic       clrPortsHi,
  output logic       romOverlay
);
  tmrCtl_t    ctl;
  logic [7:0] ctrlByte;

  sndTimerCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .ctl(ctl), .ctrlByte(ctrlByte),
    .clrPortsLo(clrPortsLo), .clrPortsHi(clrPortsHi), .romOverlay(romOverlay)
  );

  sndTimerDp #(.CNT_W(4), .FAST_MASK(3'b100)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .tickSlow(tickSlow),
    .tickFast(tickFast), .rdEn(rdEn), .addr(addr),
    .ctrlByte(ctrlByte), .rdData(rdData)
  );
endmodule

// File: tb/sndTimerCtl_tb.sv
`timescale 1ns/1ps
module sndTimerCtl_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0, tickSlow = 1'b0, tickFast = 1'b0;
  logic [7:0] addr = 8'h00, wrData = 8'h00;
  logic [7:0] rdData;
  logic clrPortsLo, clrPortsHi, romOverlay;
  int nChk = 0, nFail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sndTimerCtl u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .tickSlow(tickSlow), .tickFast(tickFast),
    .clrPortsLo(clrPortsLo), .clrPortsHi(clrPortsHi), .romOverlay(romOverlay)
  );

  // {timer[1:0], target[7:0], ticks[15:0], expected[3:0]} ; R3 R4 R6
  localparam logic [29:0] VEC [7] = '{
    {2'd0, 8'd3,   16'd10,  4'd3},
    {2'd0, 8'd0,   16'd256, 4'd1},
    {2'd1, 8'd5,   16'd20,  4'd4},
    {2'd1, 8'd1,   16'd17,  4'd1},
    {2'd2, 8'd2,   16'd9,   4'd4},
    {2'd1, 8'd255, 16'd255, 4'd1},
    {2'd2, 8'd0,   16'd255, 4'd0}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0; addr = 8'h00;
  endtask

  task automatic rdChk(input string req, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk); rdEn = 1'b1; addr = a;
    #1 chk(req, rdData, exp);
    @(negedge clk); rdEn = 1'b0; addr = 8'h00;
  endtask

  task automatic ticks(input int n, input bit fast);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (fast) tickFast = 1'b1; else tickSlow = 1'b1;
      @(negedge clk);
      tickFast = 1'b0; tickSlow = 1'b0;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 overlay", {7'b0, romOverlay}, 8'h01);
    chk("R1 strobes", {6'b0, clrPortsHi, clrPortsLo}, 8'h00);
    rdChk("R1 ctrl", 8'hF1, 8'h80);
    rdChk("R1 cnt0", 8'hFD, 8'h00);
    rdChk("R1 cnt2", 8'hFF, 8'h00);
    rdChk("R2 unmapped", 8'h42, 8'h00);
    // R1 target 0 after reset means period 256
    wr(8'hF1, 8'h81);
    ticks(255, 1'b0);
    rdChk("R1 reset target", 8'hFD, 8'h00);
    ticks(1, 1'b0);
    rdChk("R1 reset target", 8'hFD, 8'h01);
    wr(8'hF1, 8'h80);

    // vector table
    for (int v = 0; v < 7; v++) begin
      logic [1:0] t;
      t = VEC[v][29:28];
      wr(8'hFA + 8'(t), VEC[v][27:20]);
      wr(8'hF1, 8'h80 | (8'h01 << t));
      ticks(int'(VEC[v][19:4]), t == 2'd2);
      rdChk("R3/R4/R6 vector", 8'hFD + 8'(t), {4'b0, VEC[v][3:0]});
      wr(8'hF1, 8'h80);
    end

    // R4: wrong tick source and ticks while disabled
    wr(8'hFA, 8'd1);
    wr(8'hF1, 8'h81);
    ticks(3, 1'b1);
    rdChk("R4 fast ignored by timer0", 8'hFD, 8'h00);
    ticks(3, 1'b0);
    wr(8'hF1, 8'h80);
    ticks(5, 1'b0);
    rdChk("R4 disabled holds", 8'hFD, 8'h03);

    // R5: re-enable of running timer does nothing; fresh enable restarts
    wr(8'hFA, 8'd2);
    wr(8'hF1, 8'h81);
    ticks(3, 1'b0);
    wr(8'hF1, 8'h81);
    ticks(1, 1'b0);
    rdChk("R5 no restart", 8'hFD, 8'h02);
    ticks(3, 1'b0);
    wr(8'hF1, 8'h80);
    wr(8'hF1, 8'h81);
    ticks(1, 1'b0);
    rdChk("R5 restart clears", 8'hFD, 8'h00);
    wr(8'hF1, 8'h80);

    // R6: wrap past 15
    wr(8'hFA, 8'd1);
    wr(8'hF1, 8'h81);
    ticks(18, 1'b0);
    rdChk("R6 wrap", 8'hFD, 8'h02);

    // R7: read with simultaneous increment
    ticks(2, 1'b0);
    @(negedge clk); rdEn = 1'b1; addr = 8'hFD; tickSlow = 1'b1;
    #1 chk("R7 read value", rdData, 8'h02);
    @(negedge clk); rdEn = 1'b0; addr = 8'h00; tickSlow = 1'b0;
    rdChk("R7 kept increment", 8'hFD, 8'h01);
    rdChk("R7 cleared", 8'hFD, 8'h00);
    wr(8'hF1, 8'h80);

    // R8 strobes
    @(negedge clk); wrEn = 1'b1; addr = 8'hF1; wrData = 8'h90;
    @(negedge clk); wrEn = 1'b0; addr = 8'h00;
    chk("R8 lo pulse", {6'b0, clrPortsHi, clrPortsLo}, 8'h01);
    @(negedge clk);
    chk("R8 lo ends", {6'b0, clrPortsHi, clrPortsLo}, 8'h00);
    @(negedge clk); wrEn = 1'b1; addr = 8'hF1; wrData = 8'hA0;
    @(negedge clk); wrEn = 1'b0; addr = 8'h00;
    chk("R8 hi pulse", {6'b0, clrPortsHi, clrPortsLo}, 8'h02);
    @(negedge clk);
    chk("R8 hi ends", {6'b0, clrPortsHi, clrPortsLo}, 8'h00);

    // R9 overlay
    wr(8'hF1, 8'h00);
    chk("R9 overlay off", {7'b0, romOverlay}, 8'h00);
    rdChk("R2 ctrl readback", 8'hF1, 8'h00);
    wr(8'hF1, 8'h80);
    chk("R9 overlay on", {7'b0, romOverlay}, 8'h01);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule